// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It runs the command bus through the start-up sequence the memory needs before any normal access can be made. From reset it keeps clock enable and both data-mask lines high and places only no-operation commands on the bus. It holds that state for a stable period given in microseconds and turned into clock cycles through a clock-frequency parameter. It then closes all banks, issues a parameterised number of auto-refresh commands and programs the mode register. A parameter chooses whether the mode register is loaded before or after the refreshes.

Every command is one cycle wide. Each is followed by no-operation cycles until its recovery time has passed: the precharge time after precharge-all, the refresh cycle time after each refresh and the mode-register delay after the load. All three are given in clock cycles. When the last recovery time has passed, the done flag goes high. It stays high, with the bus idle, until the next reset. The normal access controller takes over the bus from that point.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: Clock enable `cke` and every bit of `dqm` are high during reset and in every cycle after it.
- R2: The command pins {cs_n, ras_n, cas_n, we_n} carry NOP (4'b0111) during reset, and for exactly WAIT_CYC = CLK_MHZ*STABLE_US cycles counted from the first rising edge with reset released. No other command appears before that count is complete.
- R3: In the cycle after the hold, precharge-all (4'b0010) is driven for one cycle with `addr[10]` high and `ba` zero.
- R4: Auto-refresh (4'b0001) is issued REF_COUNT times. A REF_COUNT below 2 is treated as 2.
- R5: Mode-register load (4'b0000) is issued exactly once, for one cycle, with `addr` equal to MODE_WORD and `ba` zero.
- R6: With MRS_FIRST = 0, all refreshes come before the mode-register load. With MRS_FIRST = 1, the load comes directly after precharge and the refreshes follow it.
- R7: The next command starts T_RP cycles after a precharge, T_RC cycles after a refresh and T_MRD cycles after the mode-register load, with NOP in between. Any of these delays below 1 is treated as 1.
- R8: `init_done` is low until the recovery time of the last command has run out. It rises in the cycle where a further command would otherwise start. It then stays high with the bus at NOP until reset.
- R9: An active-low asynchronous reset at any point, including in the middle of the sequence, returns the outputs to the reset state. The whole sequence then restarts, including the full hold period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | DQM_W | Data mask lines, held high |
| addr | output | ADDR_W | Address bus; bit 10 flags all banks, carries the mode word on load |
| ba | output | BA_W | Bank address, zero during initialization |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench runs two configurations side by side. The first has the full 200 µs hold at 250 MHz, refresh-first order and a refresh count of one that must be raised to two. The second has mode-set-first order, three refreshes, the shortest precharge delay and a zero mode-register delay that must be raised to one. Each command and the rise of `init_done` is matched to an exact cycle. A hold counter that is off by one, a recovery delay that is not clamped, a missing refresh or the wrong order would each shift or change a command that the scoreboard expects. A mid-sequence reset follows, placed just after the second configuration has sent its mode-register load. A design that resumed from where it stopped, or that shortened the second hold, would issue its refresh too early.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Commands the sequencer can place on the bus
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } sdram_cmd_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_GAP  = 2'd1,
        PH_DONE = 2'd2
    } seq_phase_e;

    // Control-pin image {cs_n, ras_n, cas_n, we_n}
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic int clamp_min(input int value, input int floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    typedef struct packed {
        logic [W-1:0] count;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.count = load_val;
        end else if (cur_q.count != '0) begin
            nxt_d.count = cur_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.count <= W'(RST_VAL);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign expired = (cur_q.count == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int REF_N     = 2,
    parameter int REF_W     = 2,
    parameter int MRS_FIRST = 0,
    parameter int GAP_PRE   = 3,
    parameter int GAP_REF   = 8,
    parameter int GAP_MRS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output sdram_cmd_e       cmd,
    output logic             cke,
    output logic             mask_hi,
    output logic             done
);

    typedef struct packed {
        seq_phase_e       phase;
        logic [REF_W-1:0] refs;
        logic             mrs_done;
        sdram_cmd_e       cmd;
        logic             done;
        logic             cke;
        logic             mask_hi;
    } fsm_t;

    fsm_t       cur_q, nxt_d;
    sdram_cmd_e issue;
    logic       refs_left;
    logic       want_mrs;

    assign refs_left = (cur_q.refs < REF_W'(REF_N));

    // Order variant picked at elaboration
    generate
        if (MRS_FIRST != 0) begin : g_mrs_first
            assign want_mrs = !cur_q.mrs_done;
        end else begin : g_ref_first
            assign want_mrs = !cur_q.mrs_done && !refs_left;
        end
    endgenerate

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.cmd     = CMD_NOP;
        nxt_d.cke     = 1'b1;
        nxt_d.mask_hi = 1'b1;
        issue         = CMD_NOP;
        tmr_load      = 1'b0;
        tmr_val       = '0;

        case (cur_q.phase)
            PH_HOLD: begin
                if (tmr_zero) begin
                    issue = CMD_PRE;
                end
            end
            PH_GAP: begin
                if (tmr_zero) begin
                    if (want_mrs) begin
                        issue = CMD_MRS;
                    end else if (refs_left) begin
                        issue = CMD_REF;
                    end else begin
                        nxt_d.phase = PH_DONE;
                        nxt_d.done  = 1'b1;
                    end
                end
            end
            PH_DONE: begin
                nxt_d.done = 1'b1;
            end
            default: begin
                nxt_d.phase = PH_HOLD;
            end
        endcase

        case (issue)
            CMD_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(GAP_PRE - 1);
            end
            CMD_REF: begin
                tmr_load   = 1'b1;
                tmr_val    = TMR_W'(GAP_REF - 1);
                nxt_d.refs = cur_q.refs + 1'b1;
            end
            CMD_MRS: begin
                tmr_load       = 1'b1;
                tmr_val        = TMR_W'(GAP_MRS - 1);
                nxt_d.mrs_done = 1'b1;
            end
            default: begin
                tmr_load = 1'b0;
            end
        endcase

        if (issue != CMD_NOP) begin
            nxt_d.cmd   = issue;
            nxt_d.phase = PH_GAP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase    <= PH_HOLD;
            cur_q.refs     <= '0;
            cur_q.mrs_done <= 1'b0;
            cur_q.cmd      <= CMD_NOP;
            cur_q.done     <= 1'b0;
            cur_q.cke      <= 1'b1;
            cur_q.mask_hi  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cmd     = cur_q.cmd;
    assign cke     = cur_q.cke;
    assign mask_hi = cur_q.mask_hi;
    assign done    = cur_q.done;

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int              ADDR_W    = 13,
    parameter int              BA_W      = 2,
    parameter int              ALLBK_BIT = 10,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  sdram_cmd_e        cmd,
    output cmd_pins_t         pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    always_comb begin
        pins = 4'b0111;
        addr = '0;
        ba   = '0;
        case (cmd)
            CMD_PRE: begin
                pins            = 4'b0010;
                addr[ALLBK_BIT] = 1'b1;
            end
            CMD_REF: pins = 4'b0001;
            CMD_MRS: begin
                pins = 4'b0000;
                addr = MODE_WORD;
            end
            default: pins = 4'b0111;
        endcase
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int                CLK_MHZ   = 250,
    parameter int                STABLE_US = 200,
    parameter int                T_RP      = 3,
    parameter int                T_RC      = 8,
    parameter int                T_MRD     = 2,
    parameter int                REF_COUNT = 2,
    parameter int                MRS_FIRST = 0,
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [DQM_W-1:0]  dqm,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int WAIT_CYC  = CLK_MHZ * STABLE_US;
    localparam int REF_N     = clamp_min(REF_COUNT, 2);
    localparam int REF_W     = $clog2(REF_N + 1);
    localparam int GAP_PRE   = clamp_min(T_RP, 1);
    localparam int GAP_REF   = clamp_min(T_RC, 1);
    localparam int GAP_MRS   = clamp_min(T_MRD, 1);
    localparam int GAP_MAX   = (GAP_PRE > GAP_REF) ?
                               ((GAP_PRE > GAP_MRS) ? GAP_PRE : GAP_MRS) :
                               ((GAP_REF > GAP_MRS) ? GAP_REF : GAP_MRS);
    localparam int TMR_W     = $clog2(WAIT_CYC + GAP_MAX + 2);
    localparam int ALLBK_BIT = 10;

    logic             tmr_zero;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    sdram_cmd_e       cmd;
    logic             mask_hi;
    cmd_pins_t        pins;

    sdram_init_timer #(
        .W       (TMR_W),
        .RST_VAL (WAIT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    sdram_init_fsm #(
        .TMR_W     (TMR_W),
        .REF_N     (REF_N),
        .REF_W     (REF_W),
        .MRS_FIRST (MRS_FIRST),
        .GAP_PRE   (GAP_PRE),
        .GAP_REF   (GAP_REF),
        .GAP_MRS   (GAP_MRS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .cmd      (cmd),
        .cke      (cke),
        .mask_hi  (mask_hi),
        .done     (init_done)
    );

    sdram_cmd_enc #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .ALLBK_BIT (ALLBK_BIT),
        .MODE_WORD (MODE_WORD)
    ) u_enc (
        .cmd  (cmd),
        .pins (pins),
        .addr (addr),
        .ba   (ba)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign dqm   = {DQM_W{mask_hi}};

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int                WAIT_CYC  = 50000,
    parameter int                REF_N     = 2,
    parameter int                MRS_FIRST = 0,
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [DQM_W-1:0]  dqm,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done
);

    localparam int CW = $clog2(WAIT_CYC + 3) + 1;

    logic [3:0]    bus;
    logic          is_nop, is_pre, is_ref, is_mrs;
    logic [CW-1:0] since_q;
    logic [7:0]    refs_q;

    assign bus    = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (bus == 4'b0111);
    assign is_pre = (bus == 4'b0010);
    assign is_ref = (bus == 4'b0001);
    assign is_mrs = (bus == 4'b0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            refs_q  <= '0;
        end else begin
            if (since_q != CW'(WAIT_CYC + 1)) since_q <= since_q + 1'b1;
            if (is_ref) refs_q <= refs_q + 1'b1;
        end
    end

    // R1
    ctl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke && (&dqm));

    // R2
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> (since_q == CW'(WAIT_CYC + 1)));

    // R3
    pre_allbank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (addr[10] && (ba == '0)));

    // R5
    mrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> ((addr == MODE_WORD) && (ba == '0)));

    // R6
    mrs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (refs_q == ((MRS_FIRST != 0) ? 8'd0 : 8'(REF_N))));

    // R4
    ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (refs_q == 8'(REF_N)));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .WAIT_CYC  (WAIT_CYC),
    .REF_N     (REF_N),
    .MRS_FIRST (MRS_FIRST),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DQM_W     (DQM_W),
    .MODE_WORD (MODE_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dqm       (dqm),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_tb.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb;

    localparam logic [12:0] MODE_A = 13'h033;
    localparam logic [12:0] MODE_B = 13'h022;
    localparam logic [3:0]  K_NOP  = 4'b0111;
    localparam logic [3:0]  K_PRE  = 4'b0010;
    localparam logic [3:0]  K_REF  = 4'b0001;
    localparam logic [3:0]  K_MRS  = 4'b0000;
    localparam logic [3:0]  K_DONE = 4'b1111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cke_w [2];
    logic [1:0]  dqm_w [2];
    logic [12:0] addr_w [2];
    logic [1:0]  ba_w [2];
    logic        done_w [2];
    logic        cs_w [2], ras_w [2], cas_w [2], we_w [2];

    // Refresh-first, count 1 clamped to 2, full 200 us hold at 250 MHz
    sdram_pwrup_seq #(
        .CLK_MHZ(250), .STABLE_US(200), .T_RP(3), .T_RC(8), .T_MRD(2),
        .REF_COUNT(1), .MRS_FIRST(0), .MODE_WORD(MODE_A)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke_w[0]), .cs_n(cs_w[0]),
        .ras_n(ras_w[0]), .cas_n(cas_w[0]), .we_n(we_w[0]), .dqm(dqm_w[0]),
        .addr(addr_w[0]), .ba(ba_w[0]), .init_done(done_w[0])
    );

    // Mode-set-first, three refreshes, shortest gaps, T_MRD 0 clamped to 1
    sdram_pwrup_seq #(
        .CLK_MHZ(10), .STABLE_US(200), .T_RP(1), .T_RC(4), .T_MRD(0),
        .REF_COUNT(3), .MRS_FIRST(1), .MODE_WORD(MODE_B)
    ) u_dut_b (
        .clk(clk), .rst_n(rst_n), .cke(cke_w[1]), .cs_n(cs_w[1]),
        .ras_n(ras_w[1]), .cas_n(cas_w[1]), .we_n(we_w[1]), .dqm(dqm_w[1]),
        .addr(addr_w[1]), .ba(ba_w[1]), .init_done(done_w[1])
    );

    typedef struct {
        logic [3:0] code;
        int         cyc;
    } exp_t;

    exp_t sb [2][$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc [2];
    logic prev_done [2];
    logic rst_seen = 1'b0;
    bit   finished = 1'b0;

    always @(posedge clk) rst_seen <= rst_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int i, input logic [3:0] code, input int c);
        exp_t e;
        e.code = code;
        e.cyc  = c;
        sb[i].push_back(e);
    endtask

    // Driver: expected event list for one full run of both instances
    task automatic load_expect();
        sb[0].delete();
        sb[1].delete();
        push(0, K_PRE, 50001); push(0, K_REF, 50004); push(0, K_REF, 50012);
        push(0, K_MRS, 50020); push(0, K_DONE, 50022);
        push(1, K_PRE, 2001); push(1, K_MRS, 2002); push(1, K_REF, 2003);
        push(1, K_REF, 2007); push(1, K_REF, 2011); push(1, K_DONE, 2015);
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(cke_w[i] && (dqm_w[i] == 2'b11), "R1", "cke/dqm in reset",
                int'({cke_w[i], dqm_w[i]}), 7);
            chk({cs_w[i], ras_w[i], cas_w[i], we_w[i]} == K_NOP, req,
                "bus NOP in reset", int'({cs_w[i], ras_w[i], cas_w[i], we_w[i]}), 7);
            chk(done_w[i] == 1'b0, req, "init_done low in reset", int'(done_w[i]), 0);
        end
    endtask

    function automatic string code_req(input logic [3:0] c);
        case (c)
            K_PRE:   return "R3";
            K_REF:   return "R4";
            K_MRS:   return "R6";
            default: return "R8";
        endcase
    endfunction

    // Monitor: pops and compares as events appear
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            logic [3:0] bus;
            bus = {cs_w[i], ras_w[i], cas_w[i], we_w[i]};
            if (!rst_n || !rst_seen) begin
                cyc[i] = 0;
                prev_done[i] = 1'b0;
            end else begin
                logic [3:0] seen;
                cyc[i]++;
                seen = K_NOP;
                if (done_w[i] && !prev_done[i]) seen = K_DONE;
                else if (bus != K_NOP) seen = bus;
                if (prev_done[i] && !done_w[i])
                    chk(1'b0, "R8", "init_done fell", 0, 1);
                if (done_w[i] && bus != K_NOP)
                    chk(1'b0, "R8", "bus busy after done", int'(bus), 7);
                if (seen != K_NOP) begin
                    if (sb[i].size() == 0) begin
                        chk(1'b0, "R8", "unexpected event code", int'(seen), 7);
                    end else begin
                        exp_t e;
                        e = sb[i].pop_front();
                        chk(seen == e.code, code_req(e.code), "event code",
                            int'(seen), int'(e.code));
                        chk(cyc[i] == e.cyc, (e.code == K_PRE) ? "R2" :
                            (e.code == K_DONE) ? "R8" : "R7", "event cycle",
                            cyc[i], e.cyc);
                        chk(cke_w[i] && (dqm_w[i] == 2'b11), "R1", "cke/dqm high",
                            int'({cke_w[i], dqm_w[i]}), 7);
                        if (seen == K_PRE)
                            chk(addr_w[i][10] && ba_w[i] == 2'b00, "R3",
                                "all-bank flag", int'(addr_w[i][10]), 1);
                        if (seen == K_MRS)
                            chk(addr_w[i] == ((i == 0) ? MODE_A : MODE_B) &&
                                ba_w[i] == 2'b00, "R5", "mode word",
                                int'(addr_w[i]), int'((i == 0) ? MODE_A : MODE_B));
                    end
                end
                prev_done[i] = done_w[i];
            end
        end
    end

    initial begin
        // Run 1: full sequence on both instances
        load_expect();
        repeat (5) @(posedge clk);
        check_idle("R2");
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (50050) @(posedge clk);
        for (int i = 0; i < 2; i++)
            chk(sb[i].size() == 0, "R4", "events left after run", sb[i].size(), 0);
        for (int i = 0; i < 2; i++)
            chk(done_w[i] == 1'b1, "R8", "init_done held", int'(done_w[i]), 1);

        // Run 2: reset, then reset again in the middle of the sequence
        @(posedge clk); #1 rst_n = 1'b0;
        load_expect();
        check_idle("R9");
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2003) @(posedge clk);
        #1 rst_n = 1'b0;
        check_idle("R9");
        load_expect();
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (50050) @(posedge clk);
        for (int i = 0; i < 2; i++)
            chk(sb[i].size() == 0, "R9", "events left after restart", sb[i].size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 150000, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule